// File: doc/BRIEF.md
# Flash Write-Cycle Qualifier with Supply Lockout

This block sits between the asynchronous bus control pins of a parallel NOR flash (chip select, write strobe and read/output strobe, all active low) and the command decoder inside the memory. It samples the three pins in a fast clock domain. It removes noise pulses that are shorter than a set number of sample clocks. It then decides whether a legitimate write cycle took place. When one completes, it presents the captured address and data for exactly one clock as a write strobe.

The block also enforces the electrical protection rules in digital form. While the supply-low lockout input is asserted, every write is dropped and a registered force-read request holds the command logic in read mode. The same request is held for a short settling window after reset and after the lockout ends. A write cycle may only begin on the falling edge of chip select or write strobe while the output strobe is high. As a result, pins that are already low when power becomes good cannot produce a command on the next rising edge of the write strobe.

Top module: `flash_wr_qualifier`

## Requirements
- R1: While `rst` is high and on the first clock after it, `force_read` is 1 and `wr_valid` is 0.
- R2: A write is recognised when `ce_n` and `we_n` are both low with `oe_n` high, and the later of the two falling edges happens while `oe_n` is high. It ends on the first rise of `we_n` or `ce_n`. The write then produces exactly one `wr_valid` pulse, with `wr_addr`/`wr_data` equal to `addr_in`/`data_in`. These bus inputs must be held stable for at least 10 clocks after the rising edge.
- R3: If `oe_n` is low when the cycle would start, or falls at any time before the cycle ends, no strobe is produced for that cycle.
- R4: While `ce_n` is high, toggling `we_n` produces no strobe.
- R5: A level on `ce_n`, `we_n` or `oe_n` that lasts fewer than GLITCH_CYCLES sample clocks (default 3) has no effect. It starts no cycle, ends no cycle and aborts no cycle.
- R6: A level held for GLITCH_CYCLES sample clocks or more is accepted. A write strobe pulse of exactly GLITCH_CYCLES clocks produces one write.
- R7: Within 6 clocks of `supply_low` rising, `force_read` is 1. No `wr_valid` occurs while `supply_low` is high.
- R8: After `supply_low` falls, `force_read` stays 1 for a settling window of about GLITCH_CYCLES+6 clocks and then returns to 0. After that, writes are accepted again.
- R9: If `ce_n` and `we_n` are both low when reset or lockout ends, the next rise of `we_n` produces no strobe. A following complete write is accepted.
- R10: `wr_valid` is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Raw chip select, active low, asynchronous |
| we_n | input | 1 | Raw write strobe, active low, asynchronous |
| oe_n | input | 1 | Raw output strobe, active low, asynchronous |
| supply_low | input | 1 | Digital supply lockout, high = supply too low |
| addr_in | input | ADDR_W | Address bus |
| data_in | input | DATA_W | Data bus |
| wr_valid | output | 1 | One-clock qualified write strobe |
| wr_addr | output | ADDR_W | Address captured for the strobe |
| wr_data | output | DATA_W | Data captured for the strobe |
| force_read | output | 1 | Request that command logic return to read mode |

## Verification
The bench targets pulses that are one clock shorter than the filter threshold on each pin, and a pulse of exactly the threshold. A filter that is off by one either lets the short noise start, end or abort a cycle, or drops the threshold-length write. It drops the output strobe in the middle of a cycle and starts cycles with the output strobe already low. A qualifier that checks levels only at the end of a cycle would then issue a write. It releases reset with chip select and write strobe already low. A design that starts cycles on levels instead of falling edges would issue a false command on the following rise. It also checks that lockout drops a complete write and keeps the read request up through the settling window.

// File: rtl/flash_wq_pkg.sv
package flash_wq_pkg;
  localparam int CH_CE = 0;
  localparam int CH_WE = 1;
  localparam int CH_OE = 2;
  localparam int N_CH  = 3;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_WRITE = 2'd2
  } wq_state_t;
endpackage

// File: rtl/flash_wq_sync.sv
module flash_wq_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/flash_wq_filter.sv
module flash_wq_filter #(
  parameter int GLITCH_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic in_s,
  output logic out
);
  localparam int CW = (GLITCH_CYCLES < 2) ? 1 : $clog2(GLITCH_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(GLITCH_CYCLES - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      out <= 1'b1;
      run <= '0;
    end else if (in_s == out) begin
      run <= '0;
    end else if (run == LAST) begin
      out <= in_s;
      run <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

  // R5: the filtered level only moves toward the level the input held
  assert_filter_follows_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(out) |-> ($past(in_s) == out));
endmodule

// File: rtl/flash_wq_fsm.sv
module flash_wq_fsm
  import flash_wq_pkg::*;
#(
  parameter int ADDR_W        = 21,
  parameter int DATA_W        = 16,
  parameter int GLITCH_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CH-1:0]   ctl_f,
  input  logic              lock_s,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              force_read
);
  localparam int SETTLE = GLITCH_CYCLES + 4;
  localparam int SW     = $clog2(SETTLE + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE - 1);

  wq_state_t     state;
  logic [SW-1:0] settle_cnt;
  logic          sel_prev;
  logic          ce_f, we_f, oe_f, sel_now, armed;

  assign ce_f    = ctl_f[CH_CE];
  assign we_f    = ctl_f[CH_WE];
  assign oe_f    = ctl_f[CH_OE];
  assign sel_now = ce_f | we_f;
  assign armed   = !ce_f && !we_f && oe_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_HOLD;
      settle_cnt <= '0;
      sel_prev   <= 1'b1;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      force_read <= 1'b1;
    end else begin
      wr_valid <= 1'b0;
      sel_prev <= sel_now;
      case (state)
        ST_HOLD: begin
          force_read <= 1'b1;
          if (lock_s) begin
            settle_cnt <= '0;
          end else if (settle_cnt == SETTLE_LAST) begin
            settle_cnt <= '0;
            force_read <= 1'b0;
            state      <= ST_IDLE;
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (lock_s) begin
            state      <= ST_HOLD;
            force_read <= 1'b1;
          end else if (armed && sel_prev) begin
            state <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (lock_s) begin
            state      <= ST_HOLD;
            force_read <= 1'b1;
          end else if (!oe_f) begin
            state <= ST_IDLE;
          end else if (sel_now) begin
            state    <= ST_IDLE;
            wr_valid <= 1'b1;
            wr_addr  <= addr_in;
            wr_data  <= data_in;
          end
        end
        default: begin
          state      <= ST_HOLD;
          force_read <= 1'b1;
        end
      endcase
    end
  end

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  assert_lock_forces_read_R7: assert property (@(posedge clk) disable iff (rst)
    lock_s |=> force_read);

  assert_no_write_in_read_R7: assert property (@(posedge clk) disable iff (rst)
    force_read |-> !wr_valid);

  assert_strobe_needs_oe_high_R3: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(oe_f));
endmodule

// File: rtl/flash_wr_qualifier.sv
module flash_wr_qualifier
  import flash_wq_pkg::*;
#(
  parameter int ADDR_W        = 21,
  parameter int DATA_W        = 16,
  parameter int GLITCH_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              supply_low,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              force_read
);
  logic [N_CH-1:0] ctl_raw, ctl_s, ctl_f;
  logic            lock_s;

  always_comb begin
    ctl_raw        = '1;
    ctl_raw[CH_CE] = ce_n;
    ctl_raw[CH_WE] = we_n;
    ctl_raw[CH_OE] = oe_n;
  end

  flash_wq_sync #(.W(N_CH), .RST_VAL({N_CH{1'b1}})) u_ctl_sync (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
  );

  flash_wq_sync #(.W(1), .RST_VAL(1'b1)) u_lock_sync (
    .clk(clk), .rst(rst), .d(supply_low), .q(lock_s)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_filt
    flash_wq_filter #(.GLITCH_CYCLES(GLITCH_CYCLES)) u_filt (
      .clk(clk), .rst(rst), .in_s(ctl_s[ch]), .out(ctl_f[ch])
    );
  end

  flash_wq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_CYCLES(GLITCH_CYCLES)
  ) u_fsm (
    .clk(clk), .rst(rst), .ctl_f(ctl_f), .lock_s(lock_s),
    .addr_in(addr_in), .data_in(data_in),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .force_read(force_read)
  );
endmodule

// File: tb/flash_wr_qualifier_test.sv
module flash_wr_qualifier_test;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int G  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, supply_low = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic wr_valid, force_read;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int total = 0, bad = 0;
  int strobes = 0, doubles = 0;
  logic prev_wv = 1'b0;
  logic [AW-1:0] last_a = '0;
  logic [DW-1:0] last_d = '0;

  always #5 clk = ~clk;

  flash_wr_qualifier #(.ADDR_W(AW), .DATA_W(DW), .GLITCH_CYCLES(G)) uut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .supply_low(supply_low), .addr_in(addr_in), .data_in(data_in),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .force_read(force_read)
  );

  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      strobes++;
      last_a = wr_addr;
      last_d = wr_data;
    end
    if (!rst && wr_valid && prev_wv) doubles++;
    prev_wv = wr_valid;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_we(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr_in = a; data_in = d; oe_n = 1'b1;
    wait_n(2); ce_n = 1'b0; wait_n(8);
    we_n = 1'b0; wait_n(8); we_n = 1'b1; wait_n(12);
    ce_n = 1'b1; wait_n(8);
  endtask

  task automatic write_ce(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr_in = a; data_in = d; oe_n = 1'b1;
    wait_n(2); we_n = 1'b0; wait_n(8);
    ce_n = 1'b0; wait_n(8); ce_n = 1'b1; wait_n(12);
    we_n = 1'b1; wait_n(8);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(force_read == 1'b1, "R1 force_read in reset", force_read, 1);
    chk(wr_valid == 1'b0, "R1 wr_valid in reset", wr_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(force_read == 1'b1, "R1 force_read after reset", force_read, 1);
    chk(wr_valid == 1'b0, "R1 wr_valid after reset", wr_valid, 0);
    wait_n(20);
    chk(force_read == 1'b0, "R8 settle ends after reset", force_read, 0);
  endtask

  task automatic t_basic;
    int c0 = strobes;
    write_we(21'h0_0555, 16'h00AA);
    chk(strobes == c0 + 1, "R2 we-controlled count", strobes - c0, 1);
    chk(last_a == 21'h0_0555, "R2 address", last_a, 21'h0_0555);
    chk(last_d == 16'h00AA, "R2 data", last_d, 16'h00AA);
    c0 = strobes;
    write_ce(21'h1_2AAA, 16'h5A3C);
    chk(strobes == c0 + 1, "R2 ce-controlled count", strobes - c0, 1);
    chk(last_a == 21'h1_2AAA, "R2 ce address", last_a, 21'h1_2AAA);
    chk(last_d == 16'h5A3C, "R2 ce data", last_d, 16'h5A3C);
  endtask

  task automatic t_inhibit;
    int c0 = strobes;
    oe_n = 1'b0; wait_n(6);
    ce_n = 1'b0; wait_n(8); we_n = 1'b0; wait_n(8);
    we_n = 1'b1; wait_n(12); ce_n = 1'b1; oe_n = 1'b1; wait_n(8);
    chk(strobes == c0, "R3 oe low throughout", strobes - c0, 0);
    ce_n = 1'b0; wait_n(8); we_n = 1'b0; wait_n(8);
    oe_n = 1'b0; wait_n(8); oe_n = 1'b1; wait_n(8);
    we_n = 1'b1; wait_n(12); ce_n = 1'b1; wait_n(8);
    chk(strobes == c0, "R3 oe dropped mid cycle", strobes - c0, 0);
    for (int i = 0; i < 3; i++) begin
      we_n = 1'b0; wait_n(8); we_n = 1'b1; wait_n(8);
    end
    wait_n(6);
    chk(strobes == c0, "R4 ce high blocks writes", strobes - c0, 0);
  endtask

  task automatic t_glitch;
    int c0 = strobes;
    ce_n = 1'b0; wait_n(8);
    we_n = 1'b0; wait_n(G - 1); we_n = 1'b1; wait_n(14);
    chk(strobes == c0, "R5 short we pulse ignored", strobes - c0, 0);
    ce_n = 1'b1; wait_n(8);
    addr_in = 21'h0_0AAA; data_in = 16'h0055;
    ce_n = 1'b0; wait_n(8); we_n = 1'b0; wait_n(8);
    we_n = 1'b1; wait_n(G - 1); we_n = 1'b0; wait_n(10);
    ce_n = 1'b1; wait_n(G - 1); ce_n = 1'b0; wait_n(10);
    oe_n = 1'b0; wait_n(G - 1); oe_n = 1'b1; wait_n(10);
    chk(strobes == c0, "R5 short highs do not end cycle", strobes - c0, 0);
    we_n = 1'b1; wait_n(12); ce_n = 1'b1; wait_n(8);
    chk(strobes == c0 + 1, "R5 cycle survives glitches", strobes - c0, 1);
    c0 = strobes;
    addr_in = 21'h1_FFFF; data_in = 16'hBEEF;
    ce_n = 1'b0; wait_n(8);
    we_n = 1'b0; wait_n(G); we_n = 1'b1; wait_n(12);
    ce_n = 1'b1; wait_n(8);
    chk(strobes == c0 + 1, "R6 threshold pulse accepted", strobes - c0, 1);
    chk(last_d == 16'hBEEF, "R6 threshold pulse data", last_d, 16'hBEEF);
  endtask

  task automatic t_lockout;
    int c0 = strobes;
    supply_low = 1'b1; wait_n(6);
    chk(force_read == 1'b1, "R7 lockout raises force_read", force_read, 1);
    write_we(21'h0_0123, 16'h1234);
    chk(strobes == c0, "R7 write dropped in lockout", strobes - c0, 0);
    chk(force_read == 1'b1, "R7 force_read held", force_read, 1);
    supply_low = 1'b0; wait_n(4);
    chk(force_read == 1'b1, "R8 settling window", force_read, 1);
    wait_n(20);
    chk(force_read == 1'b0, "R8 force_read released", force_read, 0);
    write_we(21'h0_0321, 16'h4321);
    chk(strobes == c0 + 1, "R8 writes resume", strobes - c0, 1);
  endtask

  task automatic t_powerup;
    int c0;
    rst = 1'b1; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    addr_in = 21'h0_0777; data_in = 16'h7777;
    wait_n(4); rst = 1'b0; wait_n(25);
    c0 = strobes;
    we_n = 1'b1; wait_n(12);
    chk(strobes == c0, "R9 first we rise ignored", strobes - c0, 0);
    ce_n = 1'b1; wait_n(8);
    write_we(21'h0_0888, 16'h8888);
    chk(strobes == c0 + 1, "R9 later write accepted", strobes - c0, 1);
    chk(last_a == 21'h0_0888, "R9 later write address", last_a, 21'h0_0888);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    wait_n(3);
    t_reset();
    t_basic();
    t_inhibit();
    t_glitch();
    t_lockout();
    t_powerup();
    chk(doubles == 0, "R10 strobe never two clocks", doubles, 0);
    finish_run();
  end
endmodule